// File: doc/BRIEF.md
# Nibble-Bus Firmware Store Target

This block is the target side of a four-bit-wide firmware bus. A host opens a transaction by pulling the active-low frame line while presenting a start code. It then sends a device-select nibble, seven address nibbles and a size nibble. The target compares the device-select nibble with its own four strap inputs, so up to sixteen targets can share one bus. A target that matches either returns one byte (read) or stores one byte (write), using a fixed sequence of turnaround, handshake and data slots. A target that does not match stays off the bus and counts the same slots, so it is ready for the next start.

Behind the bus side sits a simple single-byte memory port with a one-clock read latency. There is also a small register that passes a group of general-purpose input pins straight through to the bus. A configuration input is captured while reset is held. If it is high, the target never answers.

The data path is split into an input nibble and an output nibble with an enable. Pad drivers are outside this block.

Top module: `fwbus_target`

## Requirements
- R1: While reset is held and right after it is released, `bus_oe`, `mem_rd` and `mem_wr` are all low.
- R2: A transaction starts only in a clock where `frm_n` is low and `bus_in` is 4'hD (read) or 4'hE (write). A low frame with any other code leaves the target idle, and the nibbles that follow cause no drive and no memory strobe.
- R3: The target answers only when the nibble in clock 1 equals `strap_id`. Otherwise it never drives and never strobes. It is idle again in clock 19 after a read start, or clock 17 after a write start, so a start in that very clock is accepted.
- R4: Clocks 2 to 8 carry the address, most significant nibble first, and form a 28-bit address. `mem_addr` is its low `MEM_AW` bits. For a matched read to any address other than the register, `mem_rd` is high for exactly clock 10.
- R5: In a matched read, `bus_oe` is high in clocks 12 to 16 only. `bus_out` carries 4'h5, 4'h5 and 4'h0 in clocks 12, 13 and 14 (wait, wait, ready), then the data low nibble in clock 15 and the high nibble in clock 16. In all other clocks the output is released.
- R6: The read byte is the `mem_rdata` value present in clock 11, one clock after the strobe.
- R7: A read of address 28'hFBC0100 returns {3'b000, `gpin`}, with `gpin` taken in clock 11, and raises no `mem_rd`.
- R8: In a matched write, the data byte arrives low nibble first in clocks 10 and 11. The target drives 4'h0 with `bus_oe` high in clock 14 only. `mem_wr` is high for exactly clock 14, carrying the address and the assembled byte.
- R9: A matched write to 28'hFBC0100 still drives the ready nibble in clock 14, but `mem_wr` stays low and memory is unchanged.
- R10: If `frm_n` is low in any clock after the start clock, the transaction is dropped. From the next clock on, the target is idle, releases the bus and raises no further strobe.
- R11: The target takes `cfg_sel` only while reset is held. If it was high, no start is ever accepted. A change of `cfg_sel` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Bus-enable strap, low enables; taken during reset |
| strap_id | input | 4 | Device number compared with the select nibble |
| frm_n | input | 1 | Active-low frame/start line |
| bus_in | input | 4 | Nibble received from the bus |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | High when the target drives the bus |
| gpin | input | GPI_W | General-purpose input pins |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rd | output | 1 | One-clock read strobe |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the clock after `mem_rd` |

## Verification
The assertions assume that `frm_n` and `bus_in` are synchronous and settled at each rising edge. They also assume the memory behind the port answers exactly one clock after a strobe, and that `cfg_sel` is held steady for the whole reset interval. The bench changes every input only at falling edges and keeps `cfg_sel` constant across several reset clocks. It uses a registered memory model with single-clock latency. Random transactions mix reads, writes, matching and foreign device numbers, register hits and abort positions. All of them follow the fixed slot sequence, so the host never sends anything outside the protocol except the deliberate invalid start codes and frame aborts.

// File: rtl/fwbus_pkg.sv
package fwbus_pkg;

    localparam logic [3:0] CODE_RD    = 4'hD;
    localparam logic [3:0] CODE_WR    = 4'hE;
    localparam logic [3:0] SYNC_WAIT  = 4'h5;
    localparam logic [3:0] SYNC_READY = 4'h0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IDSEL,
        ST_ADDR,
        ST_MSIZE,
        ST_RTAR,
        ST_RSYNC,
        ST_RDATA,
        ST_WDATA,
        ST_WTAR,
        ST_WSYNC,
        ST_ETAR
    } fw_state_e;

endpackage

// File: rtl/fwbus_seq.sv
module fwbus_seq
    import fwbus_pkg::*;
#(
    parameter int ADDR_NIBS  = 7,
    parameter int SYNC_WAITS = 2,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sel,
    input  logic             frm_n,
    input  logic [3:0]       bus_in,
    input  logic [3:0]       strap_id,
    output fw_state_e        state,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(SYNC_WAITS);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    typedef struct packed {
        fw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             rd;
        logic             hit;
        logic             en;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d     = seq_q;
        seq_d.cnt = seq_q.cnt + ONE;
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.cnt = '0;
                if (seq_q.en && !frm_n && (bus_in == CODE_RD || bus_in == CODE_WR)) begin
                    seq_d.st  = ST_IDSEL;
                    seq_d.rd  = (bus_in == CODE_RD);
                    seq_d.hit = 1'b0;
                end
            end
            ST_IDSEL: begin
                seq_d.hit = (bus_in == strap_id);
                seq_d.st  = ST_ADDR;
                seq_d.cnt = '0;
            end
            ST_ADDR: begin
                if (seq_q.cnt == LAST_ADDR) begin
                    seq_d.st  = ST_MSIZE;
                    seq_d.cnt = '0;
                end
            end
            ST_MSIZE: begin
                seq_d.cnt = '0;
                seq_d.st  = seq_q.rd ? ST_RTAR : ST_WDATA;
            end
            ST_RTAR: begin
                if (seq_q.cnt == ONE) begin
                    seq_d.st  = ST_RSYNC;
                    seq_d.cnt = '0;
                end
            end
            ST_RSYNC: begin
                if (seq_q.cnt == LAST_WAIT) begin
                    seq_d.st  = ST_RDATA;
                    seq_d.cnt = '0;
                end
            end
            ST_RDATA: begin
                if (seq_q.cnt == ONE) begin
                    seq_d.st  = ST_ETAR;
                    seq_d.cnt = '0;
                end
            end
            ST_WDATA: begin
                if (seq_q.cnt == ONE) begin
                    seq_d.st  = ST_WTAR;
                    seq_d.cnt = '0;
                end
            end
            ST_WTAR: begin
                if (seq_q.cnt == ONE) begin
                    seq_d.st  = ST_WSYNC;
                    seq_d.cnt = '0;
                end
            end
            ST_WSYNC: begin
                seq_d.st  = ST_ETAR;
                seq_d.cnt = '0;
            end
            ST_ETAR: begin
                if (seq_q.cnt == ONE) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.cnt = '0;
            end
        endcase
        // a frame pulse inside a transaction drops it
        if (seq_q.st != ST_IDLE && !frm_n) begin
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
            seq_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= ST_IDLE;
            seq_q.cnt <= '0;
            seq_q.rd  <= 1'b0;
            seq_q.hit <= 1'b0;
            seq_q.en  <= !cfg_sel;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;
    assign cnt   = seq_q.cnt;
    assign hit   = seq_q.hit;

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && !frm_n) |=> (seq_q.st == ST_IDLE))
        else $error("frame pulse did not drop the transaction");

    assert_bad_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && (frm_n || (bus_in != CODE_RD && bus_in != CODE_WR)))
        |=> (seq_q.st == ST_IDLE))
        else $error("left idle without a valid start");

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.en |-> (seq_q.st == ST_IDLE))
        else $error("disabled target left idle");

endmodule

// File: rtl/fwbus_path.sv
module fwbus_path
    import fwbus_pkg::*;
#(
    parameter int          ADDR_NIBS = 7,
    parameter int          MEM_AW    = 19,
    parameter int          GPI_W     = 5,
    parameter int          CNT_W     = 4,
    parameter logic [27:0] REG_ADDR  = 28'hFBC0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fw_state_e         state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit,
    input  logic [3:0]        bus_in,
    input  logic [GPI_W-1:0]  gpin,
    input  logic [7:0]        mem_rdata,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic [7:0]        rdat
);

    localparam int               ADDR_W = 4 * ADDR_NIBS;
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic [7:0]        rdat;
    } path_t;

    path_t path_q, path_d;
    logic  [7:0] gpi_byte;
    logic        reg_sel;

    generate
        if (GPI_W >= 8) begin : g_gpi_wide
            assign gpi_byte = gpin[7:0];
        end else begin : g_gpi_pad
            assign gpi_byte = {{(8 - GPI_W){1'b0}}, gpin};
        end
    endgenerate

    assign reg_sel = (path_q.addr == ADDR_W'(REG_ADDR));

    always_comb begin
        path_d = path_q;
        case (state)
            ST_ADDR:  path_d.addr = {path_q.addr[ADDR_W-5:0], bus_in};
            ST_WDATA: begin
                if (cnt == '0) path_d.wdat[3:0] = bus_in;
                else           path_d.wdat[7:4] = bus_in;
            end
            ST_RTAR: begin
                if (cnt == ONE) path_d.rdat = reg_sel ? gpi_byte : mem_rdata;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= '0;
        end else begin
            path_q <= path_d;
        end
    end

    assign mem_addr  = path_q.addr[MEM_AW-1:0];
    assign mem_wdata = path_q.wdat;
    assign rdat      = path_q.rdat;
    assign mem_rd    = hit && (state == ST_RTAR) && (cnt == '0) && !reg_sel;
    assign mem_wr    = hit && (state == ST_WSYNC) && !reg_sel;

    assert_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd)
        else $error("read strobe longer than one clock");

    assert_rd_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> $stable(mem_addr))
        else $error("address moved after read strobe");

    assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr)
        else $error("write strobe longer than one clock");

    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr))
        else $error("read and write strobes together");

endmodule

// File: rtl/fwbus_drive.sv
module fwbus_drive
    import fwbus_pkg::*;
#(
    parameter int SYNC_WAITS = 2,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fw_state_e        state,
    input  logic [CNT_W-1:0] cnt,
    input  logic             hit,
    input  logic [7:0]       rdat,
    output logic [3:0]       bus_out,
    output logic             bus_oe
);

    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(SYNC_WAITS);

    always_comb begin
        bus_oe  = 1'b0;
        bus_out = 4'h0;
        case (state)
            ST_RSYNC: begin
                bus_oe  = hit;
                bus_out = (cnt < LAST_WAIT) ? SYNC_WAIT : SYNC_READY;
            end
            ST_RDATA: begin
                bus_oe  = hit;
                bus_out = (cnt == '0) ? rdat[3:0] : rdat[7:4];
            end
            ST_WSYNC: begin
                bus_oe  = hit;
                bus_out = SYNC_READY;
            end
            default: ;
        endcase
    end

    assert_ready_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && state == ST_RDATA && cnt == '0)
        |-> ($past(bus_oe) && $past(bus_out) == SYNC_READY))
        else $error("data nibble not preceded by ready");

    assert_tar_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RTAR || state == ST_WTAR || state == ST_ETAR) |-> !bus_oe)
        else $error("bus driven in a turnaround slot");

endmodule

// File: rtl/fwbus_target.sv
module fwbus_target
    import fwbus_pkg::*;
#(
    parameter int          ADDR_NIBS  = 7,
    parameter int          SYNC_WAITS = 2,
    parameter int          MEM_AW     = 19,
    parameter int          GPI_W      = 5,
    parameter logic [27:0] REG_ADDR   = 28'hFBC0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic [3:0]        strap_id,
    input  logic              frm_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [GPI_W-1:0]  gpin,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    localparam int CNT_W = $clog2(ADDR_NIBS + SYNC_WAITS + 2);

    fw_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic [7:0]       rdat;

    fwbus_seq #(
        .ADDR_NIBS (ADDR_NIBS),
        .SYNC_WAITS(SYNC_WAITS),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_sel (cfg_sel),
        .frm_n   (frm_n),
        .bus_in  (bus_in),
        .strap_id(strap_id),
        .state   (state),
        .cnt     (cnt),
        .hit     (hit)
    );

    fwbus_path #(
        .ADDR_NIBS(ADDR_NIBS),
        .MEM_AW   (MEM_AW),
        .GPI_W    (GPI_W),
        .CNT_W    (CNT_W),
        .REG_ADDR (REG_ADDR)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cnt      (cnt),
        .hit      (hit),
        .bus_in   (bus_in),
        .gpin     (gpin),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .rdat     (rdat)
    );

    fwbus_drive #(
        .SYNC_WAITS(SYNC_WAITS),
        .CNT_W     (CNT_W)
    ) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .cnt    (cnt),
        .hit    (hit),
        .rdat   (rdat),
        .bus_out(bus_out),
        .bus_oe (bus_oe)
    );

endmodule

// File: tb/fwbus_target_bench.sv
module fwbus_target_bench;

    localparam int          CLK_P  = 10;
    localparam int          MEM_AW = 19;
    localparam int          GPI_W  = 5;
    localparam logic [27:0] REG_A  = 28'hFBC0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [3:0]        strap = 4'h0;
    logic              frm_n = 1'b1;
    logic [3:0]        bus_in = 4'h0;
    logic [3:0]        bus_out;
    logic              bus_oe;
    logic [GPI_W-1:0]  gpin = '0;
    logic [MEM_AW-1:0] mem_addr;
    logic              mem_rd;
    logic              mem_wr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit en_exp = 1'b1;

    logic [7:0]        mem [256];
    logic [7:0]        exp_mem [256];
    int                rd_cnt = 0;
    int                wr_cnt = 0;
    logic [MEM_AW-1:0] last_ra = '0;
    logic [MEM_AW-1:0] last_wa = '0;
    logic [7:0]        last_wd = 8'h00;

    always #(CLK_P / 2) clk = ~clk;

    fwbus_target u_fwbus_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_sel),
        .strap_id (strap),
        .frm_n    (frm_n),
        .bus_in   (bus_in),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .gpin     (gpin),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // registered memory model, one clock of read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else begin
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt    <= rd_cnt + 1;
                last_ra   <= mem_addr;
            end
            if (mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic f, input logic [3:0] n);
        frm_n  = f;
        bus_in = n;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic cs, input logic [3:0] sid);
        rst_n   = 1'b0;
        cfg_sel = cs;
        strap   = sid;
        frm_n   = 1'b1;
        bus_in  = 4'h0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        en_exp = !cs;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        chk(bus_oe == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R1",
            "outputs after reset", {bus_oe, mem_rd, mem_wr}, 0);
    endtask

    task automatic read_cyc(input logic [3:0] id, input logic [27:0] a, input string req);
        logic [3:0] sq [19];
        logic [3:0] ov [20];
        logic       oe [20];
        bit         hit;
        bit         regs;
        int         rd0;
        int         bad;
        logic [7:0] expd;
        hit  = en_exp && (id == strap);
        regs = (a == REG_A);
        rd0  = rd_cnt;
        sq[0] = 4'hD;
        sq[1] = id;
        for (int k = 0; k < 7; k++) sq[2 + k] = a[27 - 4 * k -: 4];
        sq[9]  = 4'h0;
        sq[10] = 4'hF;
        sq[11] = 4'hF;
        for (int k = 12; k < 19; k++) sq[k] = 4'($urandom_range(15));
        expd = regs ? {3'b000, gpin} : exp_mem[a[7:0]];
        oe[0] = 1'b0;
        ov[0] = 4'h0;
        for (int i = 0; i < 19; i++) begin
            tick((i == 0) ? 1'b0 : 1'b1, sq[i]);
            oe[i + 1] = bus_oe;
            ov[i + 1] = bus_out;
        end
        bad = 0;
        for (int j = 1; j < 20; j++)
            if (oe[j] !== (hit && j >= 12 && j <= 16)) bad++;
        chk(bad == 0, req, "read drive window (R5 R3)", bad, 0);
        if (hit) begin
            chk(ov[12] == 4'h5 && ov[13] == 4'h5 && ov[14] == 4'h0, req,
                "read sync codes R5", {ov[12], ov[13], ov[14]}, 12'h550);
            chk({ov[16], ov[15]} == expd, req, "read data R6 R7",
                {ov[16], ov[15]}, expd);
        end
        chk(rd_cnt - rd0 == int'(hit && !regs), req, "read strobes R4",
            rd_cnt - rd0, int'(hit && !regs));
        if (hit && !regs)
            chk(last_ra == a[MEM_AW-1:0], req, "read address R4",
                int'(last_ra), int'(a[MEM_AW-1:0]));
    endtask

    task automatic write_cyc(input logic [3:0] id, input logic [27:0] a,
                             input logic [7:0] dat, input string req);
        logic [3:0] sq [17];
        logic [3:0] ov [18];
        logic       oe [18];
        bit         hit;
        bit         regs;
        int         wr0;
        int         bad;
        hit  = en_exp && (id == strap);
        regs = (a == REG_A);
        wr0  = wr_cnt;
        sq[0] = 4'hE;
        sq[1] = id;
        for (int k = 0; k < 7; k++) sq[2 + k] = a[27 - 4 * k -: 4];
        sq[9]  = 4'h0;
        sq[10] = dat[3:0];
        sq[11] = dat[7:4];
        sq[12] = 4'hF;
        sq[13] = 4'hF;
        for (int k = 14; k < 17; k++) sq[k] = 4'($urandom_range(15));
        oe[0] = 1'b0;
        ov[0] = 4'h0;
        for (int i = 0; i < 17; i++) begin
            tick((i == 0) ? 1'b0 : 1'b1, sq[i]);
            oe[i + 1] = bus_oe;
            ov[i + 1] = bus_out;
        end
        bad = 0;
        for (int j = 1; j < 18; j++)
            if (oe[j] !== (hit && j == 14)) bad++;
        chk(bad == 0, req, "write drive window (R8 R3)", bad, 0);
        if (hit) chk(ov[14] == 4'h0, req, "write ready code R8", ov[14], 0);
        chk(wr_cnt - wr0 == int'(hit && !regs), req, "write strobes R8 R9",
            wr_cnt - wr0, int'(hit && !regs));
        if (hit && !regs) begin
            chk(last_wa == a[MEM_AW-1:0] && last_wd == dat, req, "write address/data R8",
                {last_wa[7:0], last_wd}, {a[7:0], dat});
            exp_mem[a[7:0]] = dat;
        end
    endtask

    // a read interrupted by a frame pulse in clock pos
    task automatic abort_cyc(input int pos, input logic [27:0] a);
        logic [3:0] sq [19];
        int         rd0;
        int         bad;
        rd0 = rd_cnt;
        sq[0] = 4'hD;
        sq[1] = strap;
        for (int k = 0; k < 7; k++) sq[2 + k] = a[27 - 4 * k -: 4];
        for (int k = 9; k < 19; k++) sq[k] = 4'hF;
        for (int i = 0; i < pos; i++) tick((i == 0) ? 1'b0 : 1'b1, sq[i]);
        tick(1'b0, 4'h0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (bus_oe !== 1'b0) bad++;
            tick(1'b1, 4'($urandom_range(15)));
        end
        chk(bad == 0, "R10", "bus released after abort", bad, 0);
        chk(rd_cnt - rd0 == int'(pos >= 10 && a != REG_A), "R10", "strobes after abort",
            rd_cnt - rd0, int'(pos >= 10 && a != REG_A));
    endtask

    task automatic bad_start(input logic [3:0] code);
        int bad;
        int s0;
        s0  = rd_cnt + wr_cnt;
        bad = 0;
        tick(1'b0, code);
        if (bus_oe !== 1'b0) bad++;
        tick(1'b1, strap);
        for (int i = 0; i < 17; i++) begin
            if (bus_oe !== 1'b0) bad++;
            tick(1'b1, 4'h0);
        end
        chk(bad == 0 && rd_cnt + wr_cnt == s0, "R2", "invalid start code ignored",
            bad + rd_cnt + wr_cnt - s0, 0);
    endtask

    initial begin
        logic [27:0] a;
        logic [3:0]  id;
        void'($urandom(32'h5EED));
        @(negedge clk);
        do_reset(1'b0, 4'h3);

        // directed reads and writes
        read_cyc(4'h3, 28'h0000012, "R4");
        write_cyc(4'h3, 28'h0000034, 8'hA5, "R8");
        read_cyc(4'h3, 28'h0000034, "R6");
        write_cyc(4'h3, 28'hABCDEF7, 8'h3C, "R8");
        read_cyc(4'h3, 28'hABCDEF7, "R4");

        // general-purpose input register
        gpin = 5'h15;
        read_cyc(4'h3, REG_A, "R7");
        gpin = 5'h0A;
        read_cyc(4'h3, REG_A, "R7");
        write_cyc(4'h3, REG_A, 8'hFF, "R9");
        read_cyc(4'h3, 28'h0000100, "R9");

        // foreign device number, then back-to-back start
        read_cyc(4'h5, 28'h0000034, "R3");
        read_cyc(4'h3, 28'h0000034, "R3");
        write_cyc(4'hB, 28'h0000034, 8'h77, "R3");
        read_cyc(4'h3, 28'h0000034, "R3");

        // invalid start codes
        for (int c = 0; c < 16; c++)
            if (c != 13 && c != 14) bad_start(4'(c));
        read_cyc(4'h3, 28'h0000012, "R2");

        // aborts, directed then random
        abort_cyc(4, 28'h0000050);
        abort_cyc(13, 28'h0000050);
        for (int n = 0; n < 10; n++) abort_cyc($urandom_range(18, 2), 28'($urandom));
        read_cyc(4'h3, 28'h0000050, "R10");

        // random mix
        for (int n = 0; n < 120; n++) begin
            id   = ($urandom_range(1) == 1) ? strap : 4'($urandom_range(15));
            a    = ($urandom_range(7) == 0) ? REG_A : 28'($urandom);
            gpin = GPI_W'($urandom);
            if ($urandom_range(1) == 1) read_cyc(id, a, "R5");
            else                        write_cyc(id, a, 8'($urandom), "R8");
        end

        // interface enable captured at reset
        do_reset(1'b1, 4'hC);
        read_cyc(4'hC, 28'h0000040, "R11");
        write_cyc(4'hC, 28'h0000040, 8'h99, "R11");
        read_cyc(4'hC, REG_A, "R11");
        do_reset(1'b0, 4'hC);
        cfg_sel = 1'b1;
        read_cyc(4'hC, 28'h0000040, "R11");
        write_cyc(4'hC, 28'h0000041, 8'h5A, "R11");
        read_cyc(4'hC, 28'h0000041, "R11");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0h expected %0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule